// File: doc/BRIEF.md
# Immediate Edge Debounce Filter

This block cleans up one asynchronous digital input. The raw signal is first brought into the system clock domain by a two-stage synchronizer. Edges are then detected on every system clock. When the filter is idle, a change on the synchronized input shows up on the level output straight away, with no added filter delay. That change also opens a blanking window, which lasts a programmable number of filter-clock ticks. Inside the window the output holds its value and ignores the input.

Every edge that arrives inside the window is recorded in one of two sticky flags, one for rising edges and one for falling edges. Each flag stays set until its clear input is pulsed. A compare value of zero turns blanking off, and the output then tracks the synchronized input on every cycle. A one-cycle trigger pulse marks each change of the level output. Typical uses are contact or sensor inputs where the first edge carries the event and the bounce after it only needs to be counted.

Top module: `edge_blank_filter`

## Requirements
- R1: While reset is asserted (rstN low), levelOut, trigOut, riseGlitch and fallGlitch are all 0, and the blanking timer is cleared.
- R2: When no blanking window is open, a change on rawIn reaches levelOut after exactly two rising clock edges (synchronizer latency only).
- R3: With cmpVal nonzero, an edge seen while idle opens a blanking window. During the window, levelOut keeps the value it took on that edge, whatever rawIn does.
- R4: The blanking timer advances only on clock edges where filtTick is 1. With no ticks, the window stays open indefinitely.
- R5: The window closes on the clock edge that carries the cmpVal-th filter tick. From that edge on, levelOut again equals the synchronized input, so a level that differs from the held value appears immediately.
- R6: A rising edge of the synchronized input seen while a window is open sets riseGlitch. A falling edge seen while a window is open sets fallGlitch. The edge that opens a window sets neither flag.
- R7: riseGlitch and fallGlitch stay set until clrRise or clrFall respectively is high on a clock edge, which clears that flag. The filter never clears a flag by itself.
- R8: If a glitch edge and the clear of the same flag fall on the same clock edge, the flag ends up set.
- R9: With cmpVal equal to 0, levelOut follows every change of the synchronized input, even changes on consecutive cycles, and no glitch flag is ever set.
- R10: trigOut is 1 for exactly the system clock cycles in which levelOut differs from its value in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| filtTick | input | 1 | Filter-clock enable strobe; one system cycle per filter tick |
| rawIn | input | 1 | Asynchronous raw input |
| cmpVal | input | 16 | Blanking length in filter ticks; 0 bypasses the filter |
| clrRise | input | 1 | Clears riseGlitch on a clock edge |
| clrFall | input | 1 | Clears fallGlitch on a clock edge |
| levelOut | output | 1 | Filtered level |
| trigOut | output | 1 | One-cycle pulse on each levelOut change |
| riseGlitch | output | 1 | Sticky flag: rising edge seen inside a blanking window |
| fallGlitch | output | 1 | Sticky flag: falling edge seen inside a blanking window |

## Verification
The timer assertions assume that cmpVal does not change while a blanking window is open. If it did, the running count could sit at or above a newly written smaller limit. The stimulus table therefore changes cmpVal only after a segment long enough for any open window to close. Every directed test also starts from an idle filter. Within that limit, rawIn, filtTick and the clear inputs are driven freely, including one-cycle input pulses under bypass and a clear that lands on the same edge as a glitch.

// File: rtl/ebf_pkg.sv
package ebf_pkg;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic copyEn;   // idle: the output follows the synchronized input
    logic setRise;  // rising edge inside a blanking window
    logic setFall;  // falling edge inside a blanking window
  } ebfStrobes_t;

endpackage

// File: rtl/ebf_sync.sv
module ebf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] stageQ;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ <= '0;
        else       stageQ <= asyncIn;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ <= '0;
        else       stageQ <= {stageQ[STAGES-2:0], asyncIn};
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/ebf_ctrl.sv
module ebf_ctrl
  import ebf_pkg::*;
#(
  parameter int CMP_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             filtTick,
  input  logic [CMP_W-1:0] cmpVal,
  input  logic             edgeRise,
  input  logic             edgeFall,
  output ebfStrobes_t      strobes
);

  localparam int CNT_W = CMP_W + 1;

  logic             runQ;
  logic [CMP_W-1:0] timerQ;
  logic [CNT_W-1:0] nextCount;
  logic             reachCmp;
  logic             anyEdge;
  logic             filterOn;
  logic             startBlank;

  assign anyEdge    = edgeRise | edgeFall;
  assign filterOn   = (cmpVal != '0);
  assign startBlank = !runQ && anyEdge && filterOn;
  assign nextCount  = {1'b0, timerQ} + CNT_W'(1);
  assign reachCmp   = (nextCount >= {1'b0, cmpVal});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ   <= 1'b0;
      timerQ <= '0;
    end else if (startBlank) begin
      runQ   <= 1'b1;
      timerQ <= '0;
    end else if (runQ && filtTick) begin
      if (reachCmp) begin
        runQ   <= 1'b0;
        timerQ <= '0;
      end else begin
        timerQ <= nextCount[CMP_W-1:0];
      end
    end
  end

  always_comb begin
    strobes.copyEn  = !runQ;
    strobes.setRise = runQ && edgeRise;
    strobes.setFall = runQ && edgeFall;
  end

  // R5: while a window is open the count stays below the limit
  a_r5_timer_below_cmp : assert property (@(posedge clk) disable iff (!rstN)
    runQ |-> (timerQ < cmpVal));

  // R4: without a filter tick an open window neither moves nor closes
  a_r4_timer_waits_tick : assert property (@(posedge clk) disable iff (!rstN)
    (runQ && !filtTick) |=> (runQ && $stable(timerQ)));

  // R9: a zero limit never opens a window
  a_r9_bypass_stays_idle : assert property (@(posedge clk) disable iff (!rstN)
    (!runQ && cmpVal == '0) |=> !runQ);

endmodule

// File: rtl/ebf_datapath.sv
module ebf_datapath
  import ebf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        syncIn,
  input  ebfStrobes_t strobes,
  input  logic        clrRise,
  input  logic        clrFall,
  output logic        edgeRise,
  output logic        edgeFall,
  output logic        levelOut,
  output logic        trigOut,
  output logic        riseGlitch,
  output logic        fallGlitch
);

  logic lastInQ;
  logic heldQ;
  logic prevLevelQ;
  logic riseQ;
  logic fallQ;

  assign edgeRise = syncIn && !lastInQ;
  assign edgeFall = !syncIn && lastInQ;
  assign levelOut = strobes.copyEn ? syncIn : heldQ;
  assign trigOut  = levelOut ^ prevLevelQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastInQ    <= 1'b0;
      heldQ      <= 1'b0;
      prevLevelQ <= 1'b0;
    end else begin
      lastInQ    <= syncIn;
      heldQ      <= levelOut;
      prevLevelQ <= levelOut;
    end
  end

  // A set outranks a clear on the same edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseQ <= 1'b0;
      fallQ <= 1'b0;
    end else begin
      if (strobes.setRise)  riseQ <= 1'b1;
      else if (clrRise)     riseQ <= 1'b0;
      if (strobes.setFall)  fallQ <= 1'b1;
      else if (clrFall)     fallQ <= 1'b0;
    end
  end

  assign riseGlitch = riseQ;
  assign fallGlitch = fallQ;

  // R7: a flag only drops through its clear input
  a_r7_rise_sticky : assert property (@(posedge clk) disable iff (!rstN)
    (riseQ && !clrRise) |=> riseQ);
  a_r7_fall_sticky : assert property (@(posedge clk) disable iff (!rstN)
    (fallQ && !clrFall) |=> fallQ);

  // R8: a glitch strobe always leaves its flag set
  a_r8_rise_set_wins : assert property (@(posedge clk) disable iff (!rstN)
    strobes.setRise |=> riseGlitch);
  a_r8_fall_set_wins : assert property (@(posedge clk) disable iff (!rstN)
    strobes.setFall |=> fallGlitch);

  // R3: while a window is open the output does not move
  a_r3_hold_in_window : assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.copyEn && $past(!strobes.copyEn)) |-> $stable(levelOut));

endmodule

// File: rtl/edge_blank_filter.sv
module edge_blank_filter
  import ebf_pkg::*;
#(
  parameter int CMP_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             filtTick,
  input  logic             rawIn,
  input  logic [CMP_W-1:0] cmpVal,
  input  logic             clrRise,
  input  logic             clrFall,
  output logic             levelOut,
  output logic             trigOut,
  output logic             riseGlitch,
  output logic             fallGlitch
);

  logic        syncIn;
  logic        edgeRise;
  logic        edgeFall;
  ebfStrobes_t strobes;

  ebf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (rawIn),
    .syncOut (syncIn)
  );

  ebf_ctrl #(.CMP_W(CMP_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .filtTick (filtTick),
    .cmpVal   (cmpVal),
    .edgeRise (edgeRise),
    .edgeFall (edgeFall),
    .strobes  (strobes)
  );

  ebf_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .syncIn     (syncIn),
    .strobes    (strobes),
    .clrRise    (clrRise),
    .clrFall    (clrFall),
    .edgeRise   (edgeRise),
    .edgeFall   (edgeFall),
    .levelOut   (levelOut),
    .trigOut    (trigOut),
    .riseGlitch (riseGlitch),
    .fallGlitch (fallGlitch)
  );

endmodule

// File: tb/edge_blank_filter_bench.sv
module edge_blank_filter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NSEG       = 14;

  typedef struct packed {
    logic        raw;
    logic [15:0] cmp;
    logic [7:0]  tickEvery;  // 0: never, k: one tick every k cycles
    logic [7:0]  hold;
  } seg_t;

  localparam seg_t SEGS [NSEG] = '{
    '{1'b1, 16'd0, 8'd0, 8'd4},
    '{1'b0, 16'd0, 8'd0, 8'd1},
    '{1'b1, 16'd0, 8'd0, 8'd1},
    '{1'b0, 16'd0, 8'd0, 8'd4},
    '{1'b1, 16'd4, 8'd1, 8'd2},
    '{1'b0, 16'd4, 8'd1, 8'd2},
    '{1'b1, 16'd4, 8'd1, 8'd10},
    '{1'b0, 16'd5, 8'd3, 8'd3},
    '{1'b1, 16'd5, 8'd3, 8'd3},
    '{1'b0, 16'd5, 8'd3, 8'd30},
    '{1'b1, 16'd2, 8'd1, 8'd1},
    '{1'b0, 16'd2, 8'd1, 8'd1},
    '{1'b1, 16'd2, 8'd1, 8'd10},
    '{1'b0, 16'd2, 8'd1, 8'd10}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        filtTick = 1'b0;
  logic        rawIn = 1'b0;
  logic [15:0] cmpVal = 16'd0;
  logic        clrRise = 1'b0;
  logic        clrFall = 1'b0;
  logic        levelOut;
  logic        trigOut;
  logic        riseGlitch;
  logic        fallGlitch;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_blank_filter u_edge_blank_filter (
    .clk        (clk),
    .rstN       (rstN),
    .filtTick   (filtTick),
    .rawIn      (rawIn),
    .cmpVal     (cmpVal),
    .clrRise    (clrRise),
    .clrFall    (clrFall),
    .levelOut   (levelOut),
    .trigOut    (trigOut),
    .riseGlitch (riseGlitch),
    .fallGlitch (fallGlitch)
  );

  // Reference model: two-cycle input delay and a countdown of remaining ticks.
  logic mA, mB, mSeen, mHold, mPrevLvl, mRise, mFall;
  int   ticksLeft;
  logic expLevel, expTrig, mEdge;

  assign mEdge    = (mB != mSeen);
  assign expLevel = (ticksLeft > 0) ? mHold : mB;
  assign expTrig  = (expLevel != mPrevLvl);

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mA <= 0; mB <= 0; mSeen <= 0; mHold <= 0; mPrevLvl <= 0;
      mRise <= 0; mFall <= 0; ticksLeft <= 0;
    end else begin
      mA <= rawIn;
      mB <= mA;
      mSeen <= mB;
      mPrevLvl <= expLevel;
      if (ticksLeft == 0) begin
        if (mEdge && cmpVal != 0) begin
          ticksLeft <= int'(cmpVal);
          mHold <= mB;
        end
        mRise <= mRise & ~clrRise;
        mFall <= mFall & ~clrFall;
      end else begin
        if (filtTick) ticksLeft <= ticksLeft - 1;
        mRise <= (mEdge && mB)  ? 1'b1 : (mRise & ~clrRise);
        mFall <= (mEdge && !mB) ? 1'b1 : (mFall & ~clrFall);
      end
    end
  end

  task automatic check(input string req, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, expv, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkModel();
    string lvlReq;
    if (cmpVal == 0)        lvlReq = "R9 level";
    else if (ticksLeft > 0) lvlReq = "R3 level";
    else                    lvlReq = "R2 level";
    check(lvlReq, levelOut, expLevel);
    check("R10 trigger", trigOut, expTrig);
    check("R6 riseGlitch", riseGlitch, mRise);
    check("R6 fallGlitch", fallGlitch, mFall);
  endtask

  task automatic clearFlags();
    clrRise = 1; clrFall = 1;
    step();
    clrRise = 0; clrFall = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    rawIn = 1;
    repeat (3) @(negedge clk);
    check("R1 level", levelOut, 1'b0);
    check("R1 trigger", trigOut, 1'b0);
    check("R1 riseGlitch", riseGlitch, 1'b0);
    check("R1 fallGlitch", fallGlitch, 1'b0);
    rawIn = 0;
    rstN = 1;
    repeat (4) step();

    // Table walk
    for (int s = 0; s < NSEG; s++) begin
      for (int c = 0; c < int'(SEGS[s].hold); c++) begin
        rawIn    = SEGS[s].raw;
        cmpVal   = SEGS[s].cmp;
        filtTick = (SEGS[s].tickEvery != 0) && (c % int'(SEGS[s].tickEvery) == int'(SEGS[s].tickEvery) - 1);
        step();
        checkModel();
      end
    end
    filtTick = 0;
    cmpVal = 0;
    repeat (4) step();
    clearFlags();

    // R2/R4/R5/R6: window held open without ticks, then closed
    cmpVal = 16'd3;
    rawIn = 1;
    step();
    check("R2 latency one edge", levelOut, 1'b0);
    step();
    check("R2 latency two edges", levelOut, 1'b1);
    check("R10 pulse", trigOut, 1'b1);
    step();
    check("R10 single cycle", trigOut, 1'b0);
    rawIn = 0;
    for (int i = 0; i < 20; i++) begin
      step();
      checkModel();
    end
    check("R4 no ticks holds", levelOut, 1'b1);
    check("R6 fall in window", fallGlitch, 1'b1);
    check("R6 rise untouched", riseGlitch, 1'b0);
    filtTick = 1;
    step();
    step();
    check("R5 open before last tick", levelOut, 1'b1);
    step();
    filtTick = 0;
    check("R5 closes on last tick", levelOut, 1'b0);
    check("R10 pulse at close", trigOut, 1'b1);

    // R7: flag persists, then clears
    repeat (10) step();
    check("R7 fall sticky", fallGlitch, 1'b1);
    clrFall = 1;
    step();
    clrFall = 0;
    check("R7 fall cleared", fallGlitch, 1'b0);

    // R8: glitch and clear on the same edge
    rawIn = 1;
    repeat (4) step();
    rawIn = 0;
    step();
    step();
    clrFall = 1;
    step();
    clrFall = 0;
    check("R8 set wins", fallGlitch, 1'b1);
    rawIn = 1;
    step(); step();
    clrRise = 1;
    step();
    clrRise = 0;
    check("R8 rise set wins", riseGlitch, 1'b1);
    filtTick = 1;
    repeat (5) step();
    filtTick = 0;
    clearFlags();
    check("R7 both cleared", riseGlitch | fallGlitch, 1'b0);

    // R9: bypass follows single-cycle pulses, no flags
    cmpVal = 0;
    rawIn = 0;
    repeat (4) step();
    for (int i = 0; i < 8; i++) begin
      rawIn = ~rawIn;
      step();
      checkModel();
    end
    step(); step();
    check("R9 no rise flag", riseGlitch, 1'b0);
    check("R9 no fall flag", fallGlitch, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule